// File: doc/BRIEF.md
# Programmable AND-OR Plane Array

This block is a small logic array in which both the product-term plane and the sum plane are set by configuration bits. Every input is offered to the product-term plane twice, once as it is and once inverted. One configuration bit sits at each crossing of a literal and a product-term line and decides whether that literal belongs to the product. A second group of bits sits at each crossing of a product term and an output and decides whether that term is ORed into the output. One term can drive any number of outputs, and each output can use as many or as few terms as its equation needs. A sum-of-products equation is therefore mapped directly onto the array, with no rewriting to fit a fixed number of terms per output.

The configuration is loaded serially, one bit per clock, while `cfg_load` is high. The outputs are held at 0 during loading. After loading, the outputs are a purely combinational function of `in_vec`. The default size has 3 inputs, 8 product terms and 2 outputs, which is enough to hold a one-bit full adder. In that mapping the sum uses four terms and the carry uses three.

Top module: `pla_array`

## Requirements
- R1: After reset every configuration bit is 0, and `out_vec` is 0 for every input value.
- R2: On each rising clock edge with `cfg_load` high, one bit is shifted in from `cfg_bit`. While `cfg_load` is high, `out_vec` is 0.
- R3: The stream has N_TERM*2*N_IN product-plane bits first, then N_OUT*N_TERM sum-plane bits. In the product plane, term 0 comes first. Within each term, literal 2i is input i true and literal 2i+1 is input i inverted. In the sum plane, output 0 comes first, and within each output, term 0 comes first.
- R4: While `cfg_load` is low, the configuration holds and `cfg_bit` has no effect.
- R5: A product term is the AND of its selected literals. A term with no selected literal evaluates to 1.
- R6: A term that selects both the true and the inverted literal of the same input evaluates to 0.
- R7: Each output is the OR of the terms selected for it. An output with no selected term is 0.
- R8: One term may feed several outputs, and outputs may use different numbers of terms. A full adder with a four-term sum on output 1 and a three-term carry on output 0 yields correct results for all eight inputs.
- R9: Outside loading, `out_vec` follows `in_vec` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration shifting |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | High to shift one configuration bit per clock |
| cfg_bit | input | 1 | Serial configuration data |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
A misplaced or corrupted configuration bit shows up as a wrong output bit. It appears as soon as the load ends, for every input value whose product depends on that crossing. An exhaustive sweep of all input values after each load therefore exposes it within one sweep. A shift that slips by one position moves every literal and every term selection. This breaks the full-adder mapping and random configurations on most input values. Failing to gate the outputs during loading, or letting `cfg_bit` leak in while idle, is visible at the next output sample.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Position in the shift chain of stream bit k, for a chain of length len.
  // The first bit shifted in ends up at the most significant position.
  function automatic int chain_pos(input int len, input int k);
    return len - 1 - k;
  endfunction

  // Stream index of product-plane literal j of term t.
  function automatic int and_index(input int n_in, input int t, input int j);
    return t * 2 * n_in + j;
  endfunction

  // Stream index of sum-plane selection of term t for output o.
  function automatic int or_index(input int and_bits, input int n_term,
                                  input int o, input int t);
    return and_bits + o * n_term + t;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int LEN = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           shift_in,
  output logic [LEN-1:0] chain_q
);

  logic [LEN-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) begin
      chain_d = {chain_q[LEN-2:0], shift_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  // R4: configuration is frozen while not loading
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chain_q));

  // R2: each loading clock captures the serial bit at the chain entry
  assert_cfg_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> chain_q[0] == $past(shift_in));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 8,
  localparam int N_LIT = 2 * N_IN
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_IN-1:0]              in_vec,
  input  logic [N_TERM-1:0][N_LIT-1:0] lit_mask,
  output logic [N_TERM-1:0]            term_vec
);

  logic [N_LIT-1:0] lits;

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lits[2*i]   = in_vec[i];
      assign lits[2*i+1] = ~in_vec[i];
    end
  endgenerate

  generate
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
      // unselected literals read as 1 so they do not affect the product
      assign term_vec[t] = &(lits | ~lit_mask[t]);

      // R5: empty product line is true
      assert_empty_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lit_mask[t] == '0) |-> term_vec[t]);

      for (genvar i = 0; i < N_IN; i++) begin : g_conflict
        // R6: both polarities of one input give a false product
        assert_conflict_term_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (lit_mask[t][2*i] && lit_mask[t][2*i+1]) |-> !term_vec[t]);
      end
    end
  endgenerate

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_TERM-1:0]             term_vec,
  input  logic [N_OUT-1:0][N_TERM-1:0]  sel_mask,
  output logic [N_OUT-1:0]              sum_vec
);

  generate
    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
      assign sum_vec[o] = |(term_vec & sel_mask[o]);

      // R7: an output with no selected term stays low
      assert_empty_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mask[o] == '0) |-> !sum_vec[o]);
    end
  endgenerate

endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_bit,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);

  localparam int N_LIT    = 2 * N_IN;
  localparam int AND_BITS = N_TERM * N_LIT;
  localparam int OR_BITS  = N_OUT * N_TERM;
  localparam int CHAIN    = AND_BITS + OR_BITS;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic [1:0] rst_pipe_d;
  logic       rst_sync_n;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic [CHAIN-1:0]                 chain_q;
  logic [N_TERM-1:0][N_LIT-1:0]     lit_mask;
  logic [N_OUT-1:0][N_TERM-1:0]     sel_mask;
  logic [N_TERM-1:0]                term_vec;
  logic [N_OUT-1:0]                 sum_vec;

  pla_cfg_chain #(.LEN(CHAIN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (cfg_load),
    .shift_in (cfg_bit),
    .chain_q  (chain_q)
  );

  // unpack the chain into the two planes (stream order: product plane first)
  generate
    for (genvar t = 0; t < N_TERM; t++) begin : g_and_map
      for (genvar j = 0; j < N_LIT; j++) begin : g_lit_map
        assign lit_mask[t][j] =
          chain_q[pla_pkg::chain_pos(CHAIN, pla_pkg::and_index(N_IN, t, j))];
      end
    end
    for (genvar o = 0; o < N_OUT; o++) begin : g_or_map
      for (genvar t = 0; t < N_TERM; t++) begin : g_sel_map
        assign sel_mask[o][t] =
          chain_q[pla_pkg::chain_pos(CHAIN, pla_pkg::or_index(AND_BITS, N_TERM, o, t))];
      end
    end
  endgenerate

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_vec   (in_vec),
    .lit_mask (lit_mask),
    .term_vec (term_vec)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .term_vec (term_vec),
    .sel_mask (sel_mask),
    .sum_vec  (sum_vec)
  );

  assign out_vec = cfg_load ? '0 : sum_vec;

  // R2: outputs stay low for the whole load
  assert_quiet_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_load |-> (out_vec == '0));

  generate
    for (genvar o = 0; o < N_OUT; o++) begin : g_share_chk
      for (genvar t = 0; t < N_TERM; t++) begin : g_term_chk
        // R8: a true term drives every output that selects it
        assert_term_shared_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
          (!cfg_load && sel_mask[o][t] && term_vec[t]) |-> out_vec[o]);
      end
    end
  endgenerate

endmodule

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;

  localparam int NI  = 3;
  localparam int NT  = 8;
  localparam int NO  = 2;
  localparam int NL  = 2 * NI;
  localparam int ANB = NT * NL;
  localparam int LEN = ANB + NO * NT;

  logic          clk;
  logic          rst_n;
  logic          cfg_load;
  logic          cfg_bit;
  logic [NI-1:0] in_vec;
  logic [NO-1:0] out_vec;

  int n_checks;
  int n_fail;

  bit and_cfg [NT][NL];
  bit or_cfg  [NO][NT];

  pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_bit  (cfg_bit),
    .in_vec   (in_vec),
    .out_vec  (out_vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
    logic [NO-1:0] r;
    logic [NT-1:0] tv;
    for (int t = 0; t < NT; t++) begin
      tv[t] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (and_cfg[t][2*i]   && !x[i]) tv[t] = 1'b0;
        if (and_cfg[t][2*i+1] &&  x[i]) tv[t] = 1'b0;
      end
    end
    for (int o = 0; o < NO; o++) begin
      r[o] = 1'b0;
      for (int t = 0; t < NT; t++) if (or_cfg[o][t] && tv[t]) r[o] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int t = 0; t < NT; t++) for (int j = 0; j < NL; j++) and_cfg[t][j] = 1'b0;
    for (int o = 0; o < NO; o++) for (int t = 0; t < NT; t++) or_cfg[o][t] = 1'b0;
  endtask

  // R3: product plane first (term, then literal), then sum plane (output, then term)
  task automatic load_cfg(input bit probe);
    for (int k = 0; k < LEN; k++) begin
      @(negedge clk);
      cfg_load = 1'b1;
      if (k < ANB) cfg_bit = and_cfg[k / NL][k % NL];
      else         cfg_bit = or_cfg[(k - ANB) / NT][(k - ANB) % NT];
      if (probe && k == LEN / 2) begin
        in_vec = '1;
        #1 check("R2 outputs low while loading", out_vec, '0);
      end
    end
    @(negedge clk);
    cfg_load = 1'b0;
    cfg_bit  = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < (1 << NI); v++) begin
      in_vec = v[NI-1:0];
      #1 check(req, out_vec, model(in_vec));
    end
  endtask

  // full adder: a=in[0], b=in[1], c=in[2]; sum on output 1 (4 terms), carry on output 0 (3 terms)
  task automatic build_adder();
    clear_cfg();
    and_cfg[0][1] = 1; and_cfg[0][3] = 1; and_cfg[0][4] = 1;
    and_cfg[1][1] = 1; and_cfg[1][2] = 1; and_cfg[1][5] = 1;
    and_cfg[2][0] = 1; and_cfg[2][3] = 1; and_cfg[2][5] = 1;
    and_cfg[3][0] = 1; and_cfg[3][2] = 1; and_cfg[3][4] = 1;
    and_cfg[4][0] = 1; and_cfg[4][2] = 1;
    and_cfg[5][0] = 1; and_cfg[5][4] = 1;
    and_cfg[6][2] = 1; and_cfg[6][4] = 1;
    for (int t = 0; t < 4; t++) or_cfg[1][t] = 1;
    for (int t = 4; t < 7; t++) or_cfg[0][t] = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [NO-1:0] fa;
    n_checks = 0;
    n_fail   = 0;
    void'($urandom(32'd7411));
    rst_n = 1'b0; cfg_load = 1'b0; cfg_bit = 1'b0; in_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: cleared configuration gives zero outputs
    clear_cfg();
    for (int v = 0; v < (1 << NI); v++) begin
      in_vec = v[NI-1:0];
      #1 check("R1 reset outputs", out_vec, '0);
    end

    // R8, R3: full adder, checked against arithmetic directly
    build_adder();
    load_cfg(1'b1);
    for (int v = 0; v < 8; v++) begin
      in_vec = v[NI-1:0];
      fa = 2'(v[0] + v[1] + v[2]);
      #1 check("R8 full adder carry/sum", {out_vec[1], out_vec[0]}, {fa[0], fa[1]});
    end

    // R9: mid-cycle input change with no clock edge
    @(posedge clk); #0.5;
    in_vec = 3'b011;
    #0.5 check("R9 combinational follow", out_vec, 2'b01);
    in_vec = 3'b111;
    #0.5 check("R9 combinational follow", out_vec, 2'b11);

    // R4: cfg_bit toggling while idle leaves configuration intact
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      cfg_bit = 1'($urandom());
    end
    @(negedge clk);
    cfg_bit = 1'b0;
    sweep("R4 config held while idle");

    // R5 and R6: term 0 has a and not-a (plus b) on output 0; empty term 1 on output 1
    clear_cfg();
    and_cfg[0][0] = 1; and_cfg[0][1] = 1; and_cfg[0][2] = 1;
    or_cfg[0][0] = 1;
    or_cfg[1][1] = 1;
    load_cfg(1'b0);
    for (int v = 0; v < 8; v++) begin
      in_vec = v[NI-1:0];
      #1 check("R5 R6 empty true, conflict false", out_vec, 2'b10);
    end

    // R7: output 1 has no term, output 0 uses only c
    clear_cfg();
    and_cfg[3][4] = 1;
    or_cfg[0][3] = 1;
    load_cfg(1'b0);
    for (int v = 0; v < 8; v++) begin
      in_vec = v[NI-1:0];
      #1 check("R7 empty output low", out_vec, {1'b0, in_vec[2]});
    end

    // R5 R7 R8: random planes, shared terms likely
    for (int r = 0; r < 40; r++) begin
      for (int t = 0; t < NT; t++)
        for (int j = 0; j < NL; j++) and_cfg[t][j] = ($urandom() % 3) == 0;
      for (int o = 0; o < NO; o++)
        for (int t = 0; t < NT; t++) or_cfg[o][t] = ($urandom() % 2) == 0;
      load_cfg(r % 8 == 0);
      sweep("R5 R7 R8 random planes");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule